// File: doc/BRIEF.md
# Statically Scheduled Three-Unit Wide-Word Engine

This block is a small execution engine driven by wide instruction words. A program counter fetches one word per cycle from an internal instruction store. Each word carries an independent field for each of three functional units (an ALU, a pipelined multiplier and a combinational divider), one field per crossbar output, and a halt bit. All enabled fields act in the same cycle. There is no hazard detection and no stall: the schedule written into the words alone decides when a value is ready to be moved or used.

Each unit reads its two operands from its own local register file. Every unit writes only to its own result register. Values reach any register file only through a crossbar. Each crossbar output picks one source and one destination register per cycle, and there are few outputs (one by default). Result registers keep their value until that unit completes its next operation, so a schedule can delay a move when the crossbar is busy. Software loads programs through a simple write port, starts them with a pulse, and reads the outcome from the done flag and the flattened register-file contents.

Top module: `vliw_engine`

## Requirements
- R1: Word layout, least significant bit first, for the default of one crossbar output (49 bits). Bit 0 is halt. Bits 1..26 form the ALU field: valid, op (3 bits), srcA (3), srcB (3), imm (16). Bits 27..33 form the multiplier field: valid, srcA, srcB. Bits 34..40 form the divider field, laid out the same way. Bits 41..48 form the crossbar output field: valid, src (2), dstFile (2), dstReg (3). A start pulse sets the counter to address 0, and from then on one word executes per cycle. A program of N words whose last word is halting raises done N clock edges after the edge that samples start.
- R2: The ALU reads file 0. Op codes are 0 add, 1 subtract (A-B), 2 and, 3 or, 4 xor, 5 load imm, 6 pass A, 7 A+imm, all modulo 2^16. The result register can be routed from the next cycle and holds until the next valid ALU operation.
- R3: The multiplier reads file 1 and produces the low 16 bits of the product. A product issued in cycle t is first visible to the crossbar in cycle t+3. Routing in cycle t+1 or t+2 returns the previous product, and nothing stalls.
- R4: The divider reads file 2 and computes the unsigned floor quotient A/B. A zero divisor gives 0xFFFF. The result can be routed from the next cycle.
- R5: There are three local files of eight 16-bit registers, each with two read ports and one write port. All are visible on rfFlat, where file f, register r sits at bits [(f*8+r)*16 +: 16].
- R6: Each crossbar output selects src 0 ALU, 1 multiplier, 2 divider or 3 constant zero. It writes the selected value into dstFile (0..2; 3 writes nothing) at register dstReg at the end of the cycle, so the next word reads the new value.
- R7: A unit field whose valid bit is clear leaves that unit's result register unchanged. A crossbar field whose valid bit is clear writes no register.
- R8: The halting word still executes. After it, done stays high, the counter holds and no word executes until the next start pulse, which clears done.
- R9: When imemWe is high, imemData is stored at imemAddr on the clock edge. Words stored while idle are the ones the next run executes.
- R10: Synchronous reset clears all registers of all three files, every result register and done, and leaves the engine idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Pulse: restart the program at address 0 |
| imemWe | input | 1 | Instruction store write enable |
| imemAddr | input | 5 | Instruction store write address |
| imemData | input | 49 | Instruction word to store |
| done | output | 1 | High after a halting word has executed |
| rfFlat | output | 384 | All three register files, flattened |

## Verification
Every cycle, the embedded properties check the following: the counter steps by one while running, it freezes once done, an invalid ALU field leaves the ALU result untouched, a zero divisor yields all ones, a multiplier result changes only three cycles after an issue, and no two crossbar outputs target one file together. Only the bench scenarios show the rest. They run (A*B+C)/(D*E+F) over every combination of operand values drawn from {0, 7, 300}, which covers wrap-around and division by zero. Directed programs show that routing a product at the second cycle after issue returns the stale value, and they cover the ALU op codes, the zero source and the valid bits.

// File: rtl/vliw_pkg.sv
package vliw_pkg;
  localparam int DATA_W    = 16;
  localparam int RF_DEPTH  = 8;
  localparam int RF_AW     = $clog2(RF_DEPTH);
  localparam int NUM_FILES = 3;
  localparam int FILE_ALU  = 0;
  localparam int FILE_MUL  = 1;
  localparam int FILE_DIV  = 2;
  localparam int SEL_W     = 2;

  localparam logic [SEL_W-1:0] SRC_ALU  = 2'd0;
  localparam logic [SEL_W-1:0] SRC_MUL  = 2'd1;
  localparam logic [SEL_W-1:0] SRC_DIV  = 2'd2;
  localparam logic [SEL_W-1:0] SRC_ZERO = 2'd3;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_LDI, ALU_PASS, ALU_ADDI
  } aluOp_e;

  typedef struct packed {
    logic [DATA_W-1:0] imm;
    logic [RF_AW-1:0]  srcB;
    logic [RF_AW-1:0]  srcA;
    aluOp_e            op;
    logic              valid;
  } aluFld_t;

  typedef struct packed {
    logic [RF_AW-1:0] srcB;
    logic [RF_AW-1:0] srcA;
    logic             valid;
  } arithFld_t;

  typedef struct packed {
    logic [RF_AW-1:0] dstReg;
    logic [SEL_W-1:0] dstFile;
    logic [SEL_W-1:0] src;
    logic             valid;
  } xbarFld_t;

  // Strobes from the control to the datapath, already gated by run state
  typedef struct packed {
    aluFld_t   alu;
    arithFld_t mul;
    arithFld_t div;
  } ctlStrobe_t;

  localparam int ALU_W   = $bits(aluFld_t);
  localparam int ARITH_W = $bits(arithFld_t);
  localparam int XB_W    = $bits(xbarFld_t);
  localparam int XB_LSB  = 1 + ALU_W + 2 * ARITH_W;
endpackage

// File: rtl/vliw_ctrl.sv
module vliw_ctrl
  import vliw_pkg::*;
#(
  parameter int XBAR_OUTS  = 1,
  parameter int IMEM_DEPTH = 32,
  localparam int PC_W      = $clog2(IMEM_DEPTH),
  localparam int WORD_W    = XB_LSB + XBAR_OUTS * XB_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic                         imemWe,
  input  logic [PC_W-1:0]              imemAddr,
  input  logic [WORD_W-1:0]            imemData,
  output logic                         done,
  output ctlStrobe_t                   stb,
  output xbarFld_t [XBAR_OUTS-1:0]     xbar
);
  logic [WORD_W-1:0] imem [IMEM_DEPTH];
  logic [PC_W-1:0]   pc;
  logic              running;
  logic [WORD_W-1:0] word;
  logic              halt;

  always_ff @(posedge clk) begin
    if (imemWe) imem[imemAddr] <= imemData;
  end

  assign word = imem[pc];
  assign halt = word[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= '0;
      running <= 1'b0;
      done    <= 1'b0;
    end else if (start) begin
      pc      <= '0;
      running <= 1'b1;
      done    <= 1'b0;
    end else if (running) begin
      if (halt) begin
        running <= 1'b0;
        done    <= 1'b1;
      end else begin
        pc <= pc + 1'b1;
      end
    end
  end

  // Decode: unit fields pass through only while a word is executing
  always_comb begin
    stb.alu = aluFld_t'(word[1 +: ALU_W]);
    stb.mul = arithFld_t'(word[1 + ALU_W +: ARITH_W]);
    stb.div = arithFld_t'(word[1 + ALU_W + ARITH_W +: ARITH_W]);
    stb.alu.valid = stb.alu.valid & running;
    stb.mul.valid = stb.mul.valid & running;
    stb.div.valid = stb.div.valid & running;
  end

  for (genvar k = 0; k < XBAR_OUTS; k++) begin : g_xdec
    always_comb begin
      xbar[k] = xbarFld_t'(word[XB_LSB + k * XB_W +: XB_W]);
      xbar[k].valid = xbar[k].valid & running;
    end
  end

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (running && !halt && !start) |=> (pc == PC_W'($past(pc) + 1'b1))) // R1
    else $error("pc did not advance");
  AST_DONE_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> ($stable(pc) && done)) // R8
    else $error("pc moved after halt");
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(done && running)) // R8
    else $error("done while running");
endmodule

// File: rtl/vliw_dpath.sv
module vliw_dpath
  import vliw_pkg::*;
#(
  parameter int XBAR_OUTS = 1,
  parameter int MUL_LAT   = 3,
  localparam int MUL_STG  = MUL_LAT - 1,
  localparam int FLAT_W   = NUM_FILES * RF_DEPTH * DATA_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  ctlStrobe_t               stb,
  input  xbarFld_t [XBAR_OUTS-1:0] xbar,
  output logic [FLAT_W-1:0]        rfFlat
);
  logic [RF_AW-1:0]  rdIdxA [NUM_FILES];
  logic [RF_AW-1:0]  rdIdxB [NUM_FILES];
  logic [DATA_W-1:0] rdA    [NUM_FILES];
  logic [DATA_W-1:0] rdB    [NUM_FILES];
  logic [DATA_W-1:0] xbarVal [XBAR_OUTS];

  logic [DATA_W-1:0] aluRes, mulRes, divRes;
  logic [DATA_W-1:0] aluNext, divNext;
  logic [DATA_W-1:0] mulStage [MUL_STG];
  logic              mulStV   [MUL_STG];

  assign rdIdxA[FILE_ALU] = stb.alu.srcA;
  assign rdIdxB[FILE_ALU] = stb.alu.srcB;
  assign rdIdxA[FILE_MUL] = stb.mul.srcA;
  assign rdIdxB[FILE_MUL] = stb.mul.srcB;
  assign rdIdxA[FILE_DIV] = stb.div.srcA;
  assign rdIdxB[FILE_DIV] = stb.div.srcB;

  // Crossbar: each output selects exactly one source
  for (genvar k = 0; k < XBAR_OUTS; k++) begin : g_xsel
    always_comb begin
      case (xbar[k].src)
        SRC_ALU: xbarVal[k] = aluRes;
        SRC_MUL: xbarVal[k] = mulRes;
        SRC_DIV: xbarVal[k] = divRes;
        default: xbarVal[k] = '0;
      endcase
    end
  end

  // Split local register files: two read ports, one write port each
  for (genvar f = 0; f < NUM_FILES; f++) begin : g_file
    logic [DATA_W-1:0]    regs [RF_DEPTH];
    logic                 wEn;
    logic [RF_AW-1:0]     wIdx;
    logic [DATA_W-1:0]    wDat;
    logic [XBAR_OUTS-1:0] hits;

    always_comb begin
      wEn  = 1'b0;
      wIdx = '0;
      wDat = '0;
      hits = '0;
      // lowest-numbered output wins if a schedule breaks the one-writer rule
      for (int k = XBAR_OUTS - 1; k >= 0; k--) begin
        if (xbar[k].valid && xbar[k].dstFile == SEL_W'(f)) begin
          hits[k] = 1'b1;
          wEn     = 1'b1;
          wIdx    = xbar[k].dstReg;
          wDat    = xbarVal[k];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int r = 0; r < RF_DEPTH; r++) regs[r] <= '0;
      end else if (wEn) begin
        regs[wIdx] <= wDat;
      end
    end

    assign rdA[f] = regs[rdIdxA[f]];
    assign rdB[f] = regs[rdIdxB[f]];

    for (genvar r = 0; r < RF_DEPTH; r++) begin : g_out
      assign rfFlat[(f * RF_DEPTH + r) * DATA_W +: DATA_W] = regs[r];
    end

    AST_ONE_WRITER: assert property (@(posedge clk) disable iff (rst)
      $countones(hits) <= 1) // R6
      else $error("two crossbar outputs target one file");
  end

  // ALU
  always_comb begin
    case (stb.alu.op)
      ALU_ADD:  aluNext = rdA[FILE_ALU] + rdB[FILE_ALU];
      ALU_SUB:  aluNext = rdA[FILE_ALU] - rdB[FILE_ALU];
      ALU_AND:  aluNext = rdA[FILE_ALU] & rdB[FILE_ALU];
      ALU_OR:   aluNext = rdA[FILE_ALU] | rdB[FILE_ALU];
      ALU_XOR:  aluNext = rdA[FILE_ALU] ^ rdB[FILE_ALU];
      ALU_LDI:  aluNext = stb.alu.imm;
      ALU_PASS: aluNext = rdA[FILE_ALU];
      default:  aluNext = rdA[FILE_ALU] + stb.alu.imm;
    endcase
  end

  // Divider, single cycle
  assign divNext = (rdB[FILE_DIV] == '0) ? '1 : rdA[FILE_DIV] / rdB[FILE_DIV];

  always_ff @(posedge clk) begin
    if (rst) begin
      aluRes <= '0;
      divRes <= '0;
      mulRes <= '0;
      for (int s = 0; s < MUL_STG; s++) begin
        mulStage[s] <= '0;
        mulStV[s]   <= 1'b0;
      end
    end else begin
      if (stb.alu.valid) aluRes <= aluNext;
      if (stb.div.valid) divRes <= divNext;
      mulStV[0] <= stb.mul.valid;
      if (stb.mul.valid) mulStage[0] <= rdA[FILE_MUL] * rdB[FILE_MUL];
      for (int s = 1; s < MUL_STG; s++) begin
        mulStV[s]   <= mulStV[s-1];
        mulStage[s] <= mulStage[s-1];
      end
      if (mulStV[MUL_STG-1]) mulRes <= mulStage[MUL_STG-1];
    end
  end

  AST_ALU_HOLD: assert property (@(posedge clk) disable iff (rst)
    !stb.alu.valid |=> $stable(aluRes)) // R7
    else $error("ALU result changed without a valid op");
  AST_DIV_ZERO: assert property (@(posedge clk) disable iff (rst)
    (stb.div.valid && rdB[FILE_DIV] == '0) |=> (divRes == '1)) // R4
    else $error("zero divisor did not saturate");

  if (MUL_LAT == 3) begin : g_mulchk
    AST_MUL_WINDOW: assert property (@(posedge clk) disable iff (rst)
      !$stable(mulRes) |-> $past(stb.mul.valid, 3)) // R3
      else $error("product appeared outside its latency slot");
  end
endmodule

// File: rtl/vliw_engine.sv
module vliw_engine
  import vliw_pkg::*;
#(
  parameter int XBAR_OUTS  = 1,
  parameter int IMEM_DEPTH = 32,
  parameter int MUL_LAT    = 3,
  localparam int PC_W      = $clog2(IMEM_DEPTH),
  localparam int WORD_W    = XB_LSB + XBAR_OUTS * XB_W,
  localparam int FLAT_W    = NUM_FILES * RF_DEPTH * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              imemWe,
  input  logic [PC_W-1:0]   imemAddr,
  input  logic [WORD_W-1:0] imemData,
  output logic              done,
  output logic [FLAT_W-1:0] rfFlat
);
  ctlStrobe_t               stb;
  xbarFld_t [XBAR_OUTS-1:0] xbar;

  vliw_ctrl #(.XBAR_OUTS(XBAR_OUTS), .IMEM_DEPTH(IMEM_DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .imemWe(imemWe),
    .imemAddr(imemAddr), .imemData(imemData), .done(done),
    .stb(stb), .xbar(xbar)
  );

  vliw_dpath #(.XBAR_OUTS(XBAR_OUTS), .MUL_LAT(MUL_LAT)) u_dpath (
    .clk(clk), .rst(rst), .stb(stb), .xbar(xbar), .rfFlat(rfFlat)
  );
endmodule

// File: tb/vliw_engine_tb.sv
module vliw_engine_tb;
  import vliw_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W = XB_LSB + XB_W;

  logic clk = 1'b0;
  logic rst, start, imemWe, done;
  logic [4:0] imemAddr;
  logic [WORD_W-1:0] imemData;
  logic [NUM_FILES*RF_DEPTH*DATA_W-1:0] rfFlat;

  int checks = 0;
  int fails  = 0;
  logic [WORD_W-1:0] prog [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  vliw_engine u_dut (
    .clk(clk), .rst(rst), .start(start), .imemWe(imemWe),
    .imemAddr(imemAddr), .imemData(imemData), .done(done), .rfFlat(rfFlat)
  );

  function automatic logic [15:0] rfv(int f, int r);
    return rfFlat[(f*RF_DEPTH + r)*DATA_W +: DATA_W];
  endfunction

  function automatic aluFld_t al(aluOp_e op, int a, int b, logic [15:0] imm);
    aluFld_t x;
    x.valid = 1'b1; x.op = op; x.srcA = RF_AW'(a); x.srcB = RF_AW'(b); x.imm = imm;
    return x;
  endfunction

  function automatic arithFld_t ar(int a, int b);
    arithFld_t x;
    x.valid = 1'b1; x.srcA = RF_AW'(a); x.srcB = RF_AW'(b);
    return x;
  endfunction

  function automatic xbarFld_t xb(logic [1:0] src, int f, int r);
    xbarFld_t x;
    x.valid = 1'b1; x.src = src; x.dstFile = SEL_W'(f); x.dstReg = RF_AW'(r);
    return x;
  endfunction

  function automatic logic [WORD_W-1:0] mk(aluFld_t a, arithFld_t m, arithFld_t d,
                                          xbarFld_t x, logic h);
    return {x, d, m, a, h};
  endfunction

  task automatic chk(logic ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic loadProg(int n);
    for (int i = 0; i < n; i++) begin
      imemWe = 1'b1; imemAddr = 5'(i); imemData = prog[i];
      @(negedge clk);
    end
    imemWe = 1'b0;
  endtask

  task automatic runProg(output int cycles);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cycles = 0;
    while (!done && cycles < 100) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int cyc;
    logic [15:0] vals [3];
    aluFld_t   noA;
    arithFld_t noM;
    xbarFld_t  noX;
    vals[0] = 16'd0; vals[1] = 16'd7; vals[2] = 16'd300;
    noA = '0; noM = '0; noX = '0;
    rst = 1'b1; start = 1'b0; imemWe = 1'b0; imemAddr = '0; imemData = '0;
    @(negedge clk);
    doReset();
    // R10: reset state
    chk(rfFlat == '0, "R10 files clear", longint'(rfFlat[63:0]), 0);
    chk(done == 1'b0, "R10 done low", done, 0);
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1 idle without start", done, 0);

    // Sweep (A*B+C)/(D*E+F) over {0,7,300}^6
    for (int idx = 0; idx < 729; idx++) begin
      logic [15:0] A, B, C, D, E, F, num, den, q;
      int t;
      t = idx;
      A = vals[t % 3]; t /= 3; B = vals[t % 3]; t /= 3; C = vals[t % 3]; t /= 3;
      D = vals[t % 3]; t /= 3; E = vals[t % 3]; t /= 3; F = vals[t % 3];
      num = A * B + C;
      den = D * E + F;
      q = (den == 0) ? 16'hFFFF : num / den;
      prog[0]  = mk(al(ALU_LDI,0,0,A), noM, noM, noX, 1'b0);
      prog[1]  = mk(al(ALU_LDI,0,0,B), noM, noM, xb(SRC_ALU,1,0), 1'b0);
      prog[2]  = mk(al(ALU_LDI,0,0,D), noM, noM, xb(SRC_ALU,1,1), 1'b0);
      prog[3]  = mk(al(ALU_LDI,0,0,E), ar(0,1), noM, xb(SRC_ALU,1,2), 1'b0);
      prog[4]  = mk(al(ALU_LDI,0,0,C), noM, noM, xb(SRC_ALU,1,3), 1'b0);
      prog[5]  = mk(al(ALU_LDI,0,0,F), ar(2,3), noM, xb(SRC_ALU,0,0), 1'b0);
      prog[6]  = mk(noA, noM, noM, xb(SRC_MUL,0,1), 1'b0);
      prog[7]  = mk(al(ALU_ADD,1,0,0), noM, noM, xb(SRC_ALU,0,2), 1'b0);
      prog[8]  = mk(noA, noM, noM, xb(SRC_ALU,2,0), 1'b0);
      prog[9]  = mk(noA, noM, noM, xb(SRC_MUL,0,3), 1'b0);
      prog[10] = mk(al(ALU_ADD,3,2,0), noM, noM, noX, 1'b0);
      prog[11] = mk(noA, noM, noM, xb(SRC_ALU,2,1), 1'b0);
      prog[12] = mk(noA, noM, ar(0,1), noX, 1'b0);
      prog[13] = mk(noA, noM, noM, xb(SRC_DIV,0,4), 1'b1);
      loadProg(14);
      runProg(cyc);
      chk(cyc == 14, "R1 R8 cycle count", cyc, 14);
      chk(rfv(0,4) == q, "R2 R3 R4 R6 R9 quotient", rfv(0,4), q);
      chk(rfv(2,0) == num && rfv(2,1) == den, "R4 R5 divider operands",
          {rfv(2,0), rfv(2,1)}, {num, den});
      chk(rfv(1,0) == A && rfv(1,1) == B && rfv(1,2) == D && rfv(1,3) == E,
          "R5 multiplier file", {rfv(1,0), rfv(1,1)}, {A, B});
      repeat (3) @(negedge clk);
      chk(done && rfv(0,4) == q, "R8 frozen after halt", rfv(0,4), q);
    end

    // R3: no interlock, product visible only in the third cycle after issue
    doReset();
    chk(rfFlat == '0, "R10 files clear again", longint'(rfFlat[63:0]), 0);
    prog[0] = mk(al(ALU_LDI,0,0,16'd6), noM, noM, noX, 1'b0);
    prog[1] = mk(al(ALU_LDI,0,0,16'd5), noM, noM, xb(SRC_ALU,1,0), 1'b0);
    prog[2] = mk(noA, noM, noM, xb(SRC_ALU,1,1), 1'b0);
    prog[3] = mk(noA, ar(0,1), noM, noX, 1'b0);
    prog[4] = mk(noA, noM, noM, xb(SRC_MUL,0,0), 1'b0);
    prog[5] = mk(noA, noM, noM, xb(SRC_MUL,0,1), 1'b0);
    prog[6] = mk(noA, noM, noM, xb(SRC_MUL,0,2), 1'b1);
    loadProg(7);
    runProg(cyc);
    chk(cyc == 7, "R1 short program length", cyc, 7);
    chk(rfv(0,0) == 0, "R3 stale at t+1", rfv(0,0), 0);
    chk(rfv(0,1) == 0, "R3 stale at t+2", rfv(0,1), 0);
    chk(rfv(0,2) == 30, "R3 product at t+3", rfv(0,2), 30);

    // R7 valid bits, R2 op codes, R6 zero source
    doReset();
    prog[0] = mk(al(ALU_LDI,0,0,16'h1234), noM, noM, noX, 1'b0);
    begin
      aluFld_t dead;
      xbarFld_t deadX;
      dead = al(ALU_LDI,0,0,16'h5555); dead.valid = 1'b0;
      deadX = xb(SRC_ALU,0,2); deadX.valid = 1'b0;
      prog[1] = mk(dead, noM, noM, xb(SRC_ALU,0,0), 1'b0);
      prog[2] = mk(al(ALU_LDI,0,0,16'h7707), noM, noM, xb(SRC_ALU,0,1), 1'b0);
      prog[3] = mk(noA, noM, noM, deadX, 1'b0);
    end
    prog[4] = mk(noA, noM, noM, xb(SRC_ALU,0,3), 1'b0);
    prog[5] = mk(al(ALU_SUB,3,0,0), noM, noM, noX, 1'b0);
    prog[6] = mk(al(ALU_XOR,3,0,0), noM, noM, xb(SRC_ALU,0,4), 1'b0);
    prog[7] = mk(al(ALU_ADDI,0,0,16'h0100), noM, noM, xb(SRC_ALU,0,5), 1'b0);
    prog[8] = mk(noA, noM, noM, xb(SRC_ALU,0,6), 1'b0);
    prog[9] = mk(noA, noM, noM, xb(SRC_ZERO,0,0), 1'b1);
    loadProg(10);
    runProg(cyc);
    chk(cyc == 10, "R1 directed length", cyc, 10);
    chk(rfv(0,1) == 16'h1234, "R7 invalid ALU field held result", rfv(0,1), 16'h1234);
    chk(rfv(0,2) == 0, "R7 invalid crossbar field wrote nothing", rfv(0,2), 0);
    chk(rfv(0,3) == 16'h7707, "R2 load immediate", rfv(0,3), 16'h7707);
    chk(rfv(0,4) == 16'h64D3, "R2 subtract", rfv(0,4), 16'h64D3);
    chk(rfv(0,5) == 16'h6533, "R2 xor", rfv(0,5), 16'h6533);
    chk(rfv(0,6) == 16'h1334, "R2 add immediate", rfv(0,6), 16'h1334);
    chk(rfv(0,0) == 0, "R6 zero source", rfv(0,0), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule